// File: doc/BRIEF.md
# Prefix-Steered Accumulator ALU Core

This block is a compact 16-bit execution core. Every instruction is one byte: the upper nibble is the opcode, and the lower nibble is a register number or a small constant. The core holds sixteen 16-bit registers. The last of them (index 15) is the program counter. Instruction bytes arrive over a valid/ready stream. The core presents the counter on `fetch_addr`, so the feeding memory knows which byte to supply next.

Operations do not name their source and destination registers. Both come from a small, sticky selection state, and three prefix bytes load it: one sets the destination, one sets the source, and one sets both. A fourth prefix raises an alternate-mode bit, which turns plain add and subtract into their carry-chained forms. When no prefix has been given, the selection points at R0, so R0 works as the natural accumulator. Every non-prefix byte returns the selection to that default.

The register contents and the four flags can be observed through a combinational read port that software cannot write. This is how the core is inspected during integration.

Top module: `pfx_core`

## Requirements
- R1: After reset, every register including the program counter reads 0, all four flags are 0, and the selection state points source and destination at R0 with alternate mode off. `in_ready` is 1 from the first clock edge after reset is released.
- R2: An instruction byte splits into bits 7:4, the opcode, and bits 3:0, the field n. Opcodes: 0x0 no-op, 0x1 set destination, 0x2 set source and destination, 0x3 alternate mode, 0x4 byte merge, 0x5 add, 0x6 subtract, 0x7 AND, 0x8 OR, 0x9 XOR, 0xA copy, 0xB set source, 0xD load constant. 0xC, 0xE and 0xF behave as no-ops.
- R3: Prefix bytes (0x1, 0x2, 0x3, 0xB) add to the selection state without clearing it, so a source prefix followed by a destination prefix applies both. Prefix bytes change no register other than the program counter and no flag.
- R4: Every non-prefix byte, including no-ops, clears the selection back to R0/R0 and clears alternate mode once it has executed.
- R5: Add writes dst = src + Rn. It adds the carry flag only when alternate mode is set. It sets C to the carry out of bit 15, V to signed overflow, Z to result == 0, and S to bit 15.
- R6: Subtract writes dst = src − Rn. When alternate mode is set, it also subtracts 1 if C is 0. C = 1 means no borrow occurred. V is signed overflow. Z and S are set as in R5.
- R7: AND, OR and XOR write dst = src op Rn. They update Z and S and leave C and V unchanged.
- R8: Merge writes dst = {R7[15:8], R8[15:8]}. It sets Z to result == 0, S to bit 15, C to bit 7, and clears V.
- R9: Copy writes dst = Rn, and load constant writes dst = n zero-extended. Neither changes any flag.
- R10: An operand read of R15 returns the address of the current byte plus one. A write to R15 loads the program counter with the written value. Otherwise each accepted byte advances the counter by one.
- R11: A byte is accepted when `in_valid` and `in_ready` are both 1, and it completes in that cycle. In a cycle with no accepted byte, every register, flag and selection bit holds. `in_data` is ignored in such a cycle.
- R12: `rd_data` shows register `rd_sel` combinationally, and the flag pins show the current flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte present |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Core can take a byte this cycle |
| fetch_addr | output | 16 | Program counter, address of the next byte |
| rd_sel | input | 4 | Register index for inspection |
| rd_data | output | 16 | Contents of register rd_sel |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_s | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench uses the default build: 16-bit data and sixteen registers. With that width, random full-range operands reach carry out of bit 15 and signed overflow, and byte merge draws on real high bytes. Since all sixteen indices are reachable, random bytes also write and read R15, which exercises program-counter redirection as well as the plus-one operand view. `in_valid` is held low at random, which places stalls between prefixes and the operations they steer.

// File: rtl/pfx_core_pkg.sv
package pfx_core_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_TO    = 4'h1,
    OP_WITH  = 4'h2,
    OP_ALT   = 4'h3,
    OP_MERGE = 4'h4,
    OP_ADD   = 4'h5,
    OP_SUB   = 4'h6,
    OP_AND   = 4'h7,
    OP_OR    = 4'h8,
    OP_XOR   = 4'h9,
    OP_MOVE  = 4'hA,
    OP_FROM  = 4'hB,
    OP_RSVC  = 4'hC,
    OP_IMM   = 4'hD,
    OP_RSVE  = 4'hE,
    OP_RSVF  = 4'hF
  } opcode_e;

  typedef struct packed {
    logic s;
    logic v;
    logic c;
    logic z;
  } flags_t;

  function automatic logic is_prefix(opcode_e op);
    return (op == OP_TO) || (op == OP_WITH) || (op == OP_ALT) || (op == OP_FROM);
  endfunction

endpackage

// File: rtl/pfx_regfile.sv
module pfx_regfile #(
  parameter int W      = 16,
  parameter int N      = 16,
  parameter int PC_IDX = N - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  output logic [W-1:0]         regs_o [N]
);
  localparam int AW = $clog2(N);

  for (genvar g = 0; g < N; g++) begin : g_reg
    if (g == PC_IDX) begin : g_pc
      always_ff @(posedge clk) begin
        if (!rst_n)                           regs_o[g] <= '0;
        else if (we && (waddr == AW'(g)))     regs_o[g] <= wdata;
        else if (adv)                         regs_o[g] <= regs_o[g] + W'(1);
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (!rst_n)                           regs_o[g] <= '0;
        else if (we && (waddr == AW'(g)))     regs_o[g] <= wdata;
      end
    end
  end

  // R10: without a redirect, an accepted byte steps the counter by one
  a_r10_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !(we && (waddr == AW'(PC_IDX)))) |=> (regs_o[PC_IDX] == $past(regs_o[PC_IDX]) + W'(1)));

  // R10: a write to the counter redirects it
  a_r10_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (waddr == AW'(PC_IDX))) |=> (regs_o[PC_IDX] == $past(wdata)));

  // R11: no advance and no write keeps the counter
  a_r11_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !we) |=> $stable(regs_o[PC_IDX]));

endmodule

// File: rtl/pfx_sel.sv
module pfx_sel
  import pfx_core_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  opcode_e       op,
  input  logic [AW-1:0] fld,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          alt_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_o <= '0;
      dst_o <= '0;
      alt_o <= 1'b0;
    end else if (acc) begin
      unique case (op)
        OP_TO:   dst_o <= fld;
        OP_FROM: src_o <= fld;
        OP_WITH: begin
          src_o <= fld;
          dst_o <= fld;
        end
        OP_ALT:  alt_o <= 1'b1;
        default: begin
          src_o <= '0;
          dst_o <= '0;
          alt_o <= 1'b0;
        end
      endcase
    end
  end

  // R4: any executed non-prefix byte returns the selection to default
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !is_prefix(op)) |=> (src_o == '0 && dst_o == '0 && !alt_o));

  // R3: a destination prefix keeps the source and mode already chosen
  a_r3_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_TO) |=> (dst_o == $past(fld) && src_o == $past(src_o) && alt_o == $past(alt_o)));

  // R11: idle cycles hold the selection
  a_r11_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(src_o) && $stable(dst_o) && $stable(alt_o)));

endmodule

// File: rtl/pfx_alu.sv
module pfx_alu
  import pfx_core_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  opcode_e       op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [W-1:0]  m_hi,
  input  logic [W-1:0]  m_lo,
  input  logic [IW-1:0] imm,
  input  logic          alt,
  input  flags_t        fl_in,
  output logic [W-1:0]  res,
  output flags_t        fl_out,
  output logic          wr_en
);
  localparam int HB = W / 2;

  logic [W:0] sum_x;
  logic [W:0] dif_x;

  always_comb begin
    sum_x = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, alt & fl_in.c};
    dif_x = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, alt & ~fl_in.c};
  end

  always_comb begin
    res    = '0;
    fl_out = fl_in;
    wr_en  = 1'b0;
    unique case (op)
      OP_ADD: begin
        res      = sum_x[W-1:0];
        wr_en    = 1'b1;
        fl_out.c = sum_x[W];
        fl_out.v = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
        fl_out.z = (res == '0);
        fl_out.s = res[W-1];
      end
      OP_SUB: begin
        res      = dif_x[W-1:0];
        wr_en    = 1'b1;
        fl_out.c = ~dif_x[W];
        fl_out.v = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
        fl_out.z = (res == '0);
        fl_out.s = res[W-1];
      end
      OP_AND, OP_OR, OP_XOR: begin
        if (op == OP_AND)     res = a & b;
        else if (op == OP_OR) res = a | b;
        else                  res = a ^ b;
        wr_en    = 1'b1;
        fl_out.z = (res == '0);
        fl_out.s = res[W-1];
      end
      OP_MERGE: begin
        res      = {m_hi[W-1:HB], m_lo[W-1:HB]};
        wr_en    = 1'b1;
        fl_out.z = (res == '0);
        fl_out.s = res[W-1];
        fl_out.c = res[HB-1];
        fl_out.v = 1'b0;
      end
      OP_MOVE: begin
        res   = b;
        wr_en = 1'b1;
      end
      OP_IMM: begin
        res   = W'(imm);
        wr_en = 1'b1;
      end
      default: begin
        res   = '0;
        wr_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pfx_core.sv
module pfx_core
  import pfx_core_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [7:0]                  in_data,
  output logic                        in_ready,
  output logic [DATA_W-1:0]           fetch_addr,
  input  logic [$clog2(NUM_REGS)-1:0] rd_sel,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        flag_z,
  output logic                        flag_c,
  output logic                        flag_s,
  output logic                        flag_v
);
  localparam int AW      = $clog2(NUM_REGS);
  localparam int PC_IDX  = NUM_REGS - 1;
  localparam int MHI_IDX = 7;
  localparam int MLO_IDX = 8;

  logic              rdy_q;
  logic              acc;
  opcode_e           op;
  logic [AW-1:0]     fld;
  logic [AW-1:0]     src_sel;
  logic [AW-1:0]     dst_sel;
  logic              alt_q;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] alu_res;
  logic              alu_wr;
  flags_t            flags_q;
  flags_t            flags_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign acc      = in_valid && rdy_q;
  assign op       = opcode_e'(in_data[7:4]);
  assign fld      = in_data[AW-1:0];

  pfx_sel #(.AW(AW)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (acc),
    .op    (op),
    .fld   (fld),
    .src_o (src_sel),
    .dst_o (dst_sel),
    .alt_o (alt_q)
  );

  pfx_regfile #(.W(DATA_W), .N(NUM_REGS), .PC_IDX(PC_IDX)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (acc),
    .we     (acc && alu_wr),
    .waddr  (dst_sel),
    .wdata  (alu_res),
    .regs_o (regs)
  );

  // Operand reads of the counter see the address after the current byte.
  always_comb begin
    opa = (src_sel == AW'(PC_IDX)) ? regs[PC_IDX] + DATA_W'(1) : regs[src_sel];
    opb = (fld     == AW'(PC_IDX)) ? regs[PC_IDX] + DATA_W'(1) : regs[fld];
  end

  pfx_alu #(.W(DATA_W), .IW(AW)) u_alu (
    .op     (op),
    .a      (opa),
    .b      (opb),
    .m_hi   (regs[MHI_IDX]),
    .m_lo   (regs[MLO_IDX]),
    .imm    (fld),
    .alt    (alt_q),
    .fl_in  (flags_q),
    .res    (alu_res),
    .fl_out (flags_nx),
    .wr_en  (alu_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   flags_q <= '0;
    else if (acc) flags_q <= flags_nx;
  end

  assign fetch_addr = regs[PC_IDX];
  assign rd_data    = regs[rd_sel];
  assign flag_z     = flags_q.z;
  assign flag_c     = flags_q.c;
  assign flag_s     = flags_q.s;
  assign flag_v     = flags_q.v;

  // R11: flags hold when no byte is taken
  a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(flags_q));

  // R9: copy and constant load leave the flags alone
  a_r9_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == OP_MOVE || op == OP_IMM)) |=> (flags_q == $past(flags_q)));

  // R3: prefix bytes leave the flags alone
  a_r3_pfx_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_prefix(op)) |=> (flags_q == $past(flags_q)));

  // R8: merge result is built from the two high bytes
  a_r8_merge_val: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_MERGE) |-> (alu_res == {regs[MHI_IDX][DATA_W-1:DATA_W/2], regs[MLO_IDX][DATA_W-1:DATA_W/2]}));

  // R11: the core is ready once out of reset
  a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> in_ready);

endmodule

// File: tb/pfx_core_tb.sv
`timescale 1ns/100ps
module pfx_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic [15:0] fetch_addr;
  logic [3:0]  rd_sel = 4'd0;
  logic [15:0] rd_data;
  logic        flag_z, flag_c, flag_s, flag_v;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pfx_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .fetch_addr(fetch_addr), .rd_sel(rd_sel),
    .rd_data(rd_data), .flag_z(flag_z), .flag_c(flag_c),
    .flag_s(flag_s), .flag_v(flag_v)
  );

  // reference model state
  logic [15:0] m [16];
  logic [3:0]  ms, md;
  logic        malt;
  logic        fz, fc, fs, fv;

  function automatic logic [15:0] rv(input logic [3:0] i);
    return (i == 4'd15) ? m[15] + 16'd1 : m[i];
  endfunction

  task automatic model(input logic [7:0] b);
    logic [3:0]  op, n, d;
    logic [15:0] a, bv, r;
    logic [16:0] t;
    logic        wr;
    op = b[7:4]; n = b[3:0]; d = md;
    a = rv(ms); bv = rv(n); r = '0; wr = 1'b0;
    case (op)
      4'h1: md = n;
      4'h2: begin ms = n; md = n; end
      4'h3: malt = 1'b1;
      4'hB: ms = n;
      4'h4: begin
        r = {m[7][15:8], m[8][15:8]}; wr = 1'b1;
        fz = (r == 0); fs = r[15]; fc = r[7]; fv = 1'b0;
      end
      4'h5: begin
        t = {1'b0, a} + {1'b0, bv} + {16'd0, malt & fc};
        r = t[15:0]; wr = 1'b1; fc = t[16];
        fv = (a[15] == bv[15]) && (r[15] != a[15]);
        fz = (r == 0); fs = r[15];
      end
      4'h6: begin
        t = {1'b0, a} - {1'b0, bv} - {16'd0, malt & ~fc};
        r = t[15:0]; wr = 1'b1; fc = ~t[16];
        fv = (a[15] != bv[15]) && (r[15] != a[15]);
        fz = (r == 0); fs = r[15];
      end
      4'h7, 4'h8, 4'h9: begin
        r = (op == 4'h7) ? (a & bv) : (op == 4'h8) ? (a | bv) : (a ^ bv);
        wr = 1'b1; fz = (r == 0); fs = r[15];
      end
      4'hA: begin r = bv; wr = 1'b1; end
      4'hD: begin r = {12'd0, n}; wr = 1'b1; end
      default: ;
    endcase
    if (!(op == 4'h1 || op == 4'h2 || op == 4'h3 || op == 4'hB)) begin
      ms = 4'd0; md = 4'd0; malt = 1'b0;
    end
    if (wr && d == 4'd15) m[15] = r;
    else begin
      if (wr) m[d] = r;
      m[15] = m[15] + 16'd1;
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input logic [3:0] i, input string tag);
    rd_sel = i; #1;
    chk(tag, rd_data, m[i]);
  endtask

  task automatic chk_flags(input string tag);
    chk(tag, {12'd0, flag_s, flag_v, flag_c, flag_z}, {12'd0, fs, fv, fc, fz});
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    @(posedge clk);
    model(b);
    #1 in_valid = 1'b0; in_data = $urandom();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m[i] = '0;
    ms = 0; md = 0; malt = 0; fz = 0; fc = 0; fs = 0; fv = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 ready", {15'd0, in_ready}, 16'd1);
    chk("R1 pc", fetch_addr, 16'd0);
    chk_flags("R1 flags");
    for (int i = 0; i < 16; i++) chk_reg(i[3:0], "R1 regs");

    // R9 constant load and R3 destination prefix
    send(8'h11); send(8'hD5);
    chk_reg(4'd1, "R9 imm"); chk_reg(4'd0, "R3 r0 untouched"); chk_flags("R9 flags");
    // R3 accumulation: source then destination
    send(8'hB1); send(8'h12); send(8'h51);
    chk_reg(4'd2, "R3 from+to"); chk_flags("R5 add flags");
    // R4 default registers and clearing
    send(8'h51); send(8'h51);
    chk_reg(4'd0, "R4 default acc"); chk_reg(4'd2, "R4 r2 kept");
    // R3 with prefix
    send(8'h22); send(8'h51);
    chk_reg(4'd2, "R3 with");
    // R6 subtract with and without borrow
    send(8'h13); send(8'h61);
    chk_reg(4'd3, "R6 sub"); chk_flags("R6 no borrow");
    send(8'h15); send(8'hB4); send(8'h61);
    chk_reg(4'd5, "R6 borrow"); chk_flags("R6 borrow flags");
    send(8'h16); send(8'h3F); send(8'hB4); send(8'h64);
    chk_reg(4'd6, "R6 alt sub"); chk_flags("R6 alt flags");
    // R5 carry out then carry-chained add, then plain add ignores carry
    send(8'hB5); send(8'h17); send(8'h55);
    chk_reg(4'd7, "R5 carry out"); chk_flags("R5 carry flags");
    send(8'h30); send(8'h51);
    chk_reg(4'd0, "R5 adc"); chk_flags("R5 adc flags");
    send(8'hB5); send(8'h19); send(8'h55); send(8'h51);
    chk_reg(4'd0, "R5 plain add ignores carry");
    // R7 logic keeps C and V
    send(8'h1A); send(8'hB5); send(8'h77);
    chk_reg(4'd10, "R7 and"); chk_flags("R7 flags");
    // R8 merge
    send(8'h18); send(8'hB5); send(8'h84);
    send(8'h1B); send(8'h40);
    chk_reg(4'd11, "R8 merge"); chk_flags("R8 merge flags");
    // R9 copy keeps flags
    send(8'h1C); send(8'hAB);
    chk_reg(4'd12, "R9 move"); chk_flags("R9 move flags");
    // R10 counter read and redirect
    send(8'h1D); send(8'hAF);
    chk_reg(4'd13, "R10 pc read");
    send(8'h1F); send(8'hD3);
    chk("R10 redirect", fetch_addr, m[15]);
    // R4 reserved opcode still clears prefix
    send(8'h1E); send(8'hC0); send(8'hD9);
    chk_reg(4'd0, "R4 rsv clears"); chk_reg(4'd14, "R4 r14 kept");
    // R11 stall: garbage on in_data with valid low
    send(8'h3F); send(8'h13);
    repeat (4) begin @(negedge clk); in_data = $urandom(); end
    #1 chk("R11 stall pc", fetch_addr, m[15]); chk_flags("R11 stall flags");
    send(8'h51);
    chk_reg(4'd3, "R11 prefix survives stall");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 9) < 7);
      in_data  = $urandom();
      rd_sel   = k[3:0];
      @(posedge clk);
      if (in_valid) model(in_data);
      #1;
      chk("R2 rand reg", rd_data, m[k[3:0]]);
      chk_flags("R12 rand flags");
      chk("R10 rand pc", fetch_addr, m[15]);
    end
    @(negedge clk) in_valid = 1'b0;
    for (int i = 0; i < 16; i++) chk_reg(i[3:0], "R12 final regs");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule